// File: doc/BRIEF.md
# Selectable Arithmetic Unit

This block is a purely combinational adder-based arithmetic unit for two unsigned operands of parameterised width. Every bit position has a small four-way selector that feeds the second input of a one-bit full adder: the operand bit, its inverse, a forced zero or a forced one. The first adder input is always the A operand. A two-bit operation code picks the selector setting for all bit positions together. A separate carry-in bit enters the lowest position. Together they give eight operations: add, add with increment, subtract, subtract with borrow, increment, decrement and two forms of pass-through.

The result is reduced modulo two to the power of the width. The carry leaving the top position is a separate output. A build parameter picks how carries reach each position. One choice is a plain ripple through every position. The other splits the word into equal groups. Each group derives its internal carries in one level of lookahead logic, and the groups are chained.

Top module: `arith_sel_unit`

## Requirements
- R1: With sel_i = 2'b00 and cin_i = 0, d_o is (a_i + b_i) mod 2^WIDTH and cout_o is 1 exactly when the unsigned sum reaches 2^WIDTH.
- R2: With sel_i = 2'b00 and cin_i = 1, d_o is (a_i + b_i + 1) mod 2^WIDTH and cout_o is 1 exactly when that sum reaches 2^WIDTH.
- R3: With sel_i = 2'b01 and cin_i = 0, d_o is (a_i - b_i - 1) mod 2^WIDTH (a_i plus the bitwise inverse of b_i) and cout_o is 1 exactly when a_i > b_i.
- R4: With sel_i = 2'b01 and cin_i = 1, d_o is (a_i - b_i) mod 2^WIDTH and cout_o is 1 exactly when a_i >= b_i (no borrow).
- R5: With sel_i = 2'b10 and cin_i = 0, d_o equals a_i and cout_o is 0, whatever b_i holds.
- R6: With sel_i = 2'b10 and cin_i = 1, d_o is (a_i + 1) mod 2^WIDTH and cout_o is 1 exactly when a_i is all ones.
- R7: With sel_i = 2'b11 and cin_i = 0, d_o is (a_i - 1) mod 2^WIDTH and cout_o is 1 exactly when a_i is nonzero.
- R8: With sel_i = 2'b11 and cin_i = 1, d_o equals a_i and cout_o is 1, whatever b_i holds.
- R9: The ripple build (USE_LOOKAHEAD = 0) and the grouped lookahead build (USE_LOOKAHEAD = 1) give the same d_o and cout_o for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, always the first adder input |
| b_i | input | WIDTH | Second operand, passed through the per-bit selector |
| sel_i | input | 2 | Selector code: 00 operand, 01 inverse, 10 zero, 11 ones |
| cin_i | input | 1 | Carry into the least significant position |
| d_o | output | WIDTH | Result modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the most significant position |

## Verification
Directed vectors place the operands at the points where the carry out changes: all ones plus one, zero minus one, equal operands under subtraction, and A one above or one below B. These separate a correct carry rule from one that is off by one at the boundary. Random operands under all eight codes then exercise long carry chains and check that B is ignored in the pass and constant codes. Two builds, ripple and grouped lookahead, get the same vectors, so a fault in either carry network shows up as a mismatch with the expected value.

// File: rtl/arith_sel_pkg.sv
`timescale 1ns/1ps
package arith_sel_pkg;

   // Per-bit source for the second adder input
   typedef enum logic [1:0] {
      OPB_TRUE = 2'b00,
      OPB_INV  = 2'b01,
      OPB_ZERO = 2'b10,
      OPB_ONES = 2'b11
   } opb_sel_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/arith_opnd_mux.sv
`timescale 1ns/1ps
module arith_opnd_mux
   import arith_sel_pkg::*;
(
   input  logic             b_bit_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             y_o
);

   logic b_inv;

   assign b_inv = ~b_bit_i;

   always_comb begin
      unique case (opb_sel_e'(sel_i))
         OPB_TRUE: y_o = b_bit_i;
         OPB_INV:  y_o = b_inv;
         OPB_ZERO: y_o = 1'b0;
         OPB_ONES: y_o = 1'b1;
         default:  y_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/arith_full_add.sv
`timescale 1ns/1ps
module arith_full_add (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic gen_o,
   output logic prop_o
);

   assign gen_o  = x_i & y_i;
   assign prop_o = x_i ^ y_i;
   assign s_o    = prop_o ^ c_i;

endmodule

// File: rtl/arith_cla_group.sv
`timescale 1ns/1ps
module arith_cla_group #(
   parameter int unsigned GROUP = 4
) (
   input  logic [GROUP-1:0] gen_i,
   input  logic [GROUP-1:0] prop_i,
   input  logic             cin_i,
   output logic [GROUP-1:0] c_o
);

   // c_o[k] is the carry leaving position k, expanded to two levels
   always_comb begin
      for (int k = 0; k < GROUP; k++) begin
         logic acc;
         logic run;
         acc = gen_i[k];
         run = prop_i[k];
         for (int j = k - 1; j >= 0; j--) begin
            acc = acc | (run & gen_i[j]);
            run = run & prop_i[j];
         end
         c_o[k] = acc | (run & cin_i);
      end
   end

endmodule

// File: rtl/arith_sel_unit.sv
`timescale 1ns/1ps
module arith_sel_unit
   import arith_sel_pkg::*;
#(
   parameter int unsigned WIDTH         = 8,
   parameter bit          USE_LOOKAHEAD = 1'b0,
   parameter int unsigned GROUP         = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       sel_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] d_o,
   output logic             cout_o
);

   localparam int unsigned N_GROUPS = (GROUP == 0) ? 1 : WIDTH / GROUP;

   // Elaboration-time parameter checks
   if (WIDTH < 1) begin : g_bad_width
      $error("arith_sel_unit: WIDTH must be at least 1");
   end
   if (USE_LOOKAHEAD && (GROUP < 1 || (WIDTH % GROUP) != 0)) begin : g_bad_group
      $error("arith_sel_unit: GROUP must divide WIDTH in lookahead build");
   end

   logic [WIDTH-1:0] opb;
   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] prop;
   logic [WIDTH:0]   carry;

   assign carry[0] = cin_i;
   assign cout_o   = carry[WIDTH];

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      arith_opnd_mux u_mux (
         .b_bit_i (b_i[i]),
         .sel_i   (sel_i),
         .y_o     (opb[i])
      );
      arith_full_add u_fa (
         .x_i    (a_i[i]),
         .y_i    (opb[i]),
         .c_i    (carry[i]),
         .s_o    (d_o[i]),
         .gen_o  (gen[i]),
         .prop_o (prop[i])
      );
   end

   if (!USE_LOOKAHEAD) begin : g_ripple
      for (genvar i = 0; i < WIDTH; i++) begin : g_link
         assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
      end
   end else begin : g_lookahead
      for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
         arith_cla_group #(.GROUP(GROUP)) u_cla (
            .gen_i  (gen[g*GROUP +: GROUP]),
            .prop_i (prop[g*GROUP +: GROUP]),
            .cin_i  (carry[g*GROUP]),
            .c_o    (carry[g*GROUP+1 +: GROUP])
         );
      end
   end

endmodule

// File: rtl/arith_sel_unit_chk.sv
`timescale 1ns/1ps
module arith_sel_unit_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [1:0]       sel_i,
   input logic             cin_i,
   input logic [WIDTH-1:0] d_o,
   input logic             cout_o
);

   always_comb begin
      // R4
      sub_borrow_chk: assert (!(sel_i == 2'b01 && cin_i) || (cout_o == (a_i >= b_i)))
         else $error("subtract carry does not match a >= b");
      // R5
      pass_clear_chk: assert (!(sel_i == 2'b10 && !cin_i) || (d_o == a_i && !cout_o))
         else $error("pass with zero does not hold a and clear carry");
      // R6
      inc_wrap_chk: assert (!(sel_i == 2'b10 && cin_i) || (cout_o == (&a_i)))
         else $error("increment carry does not match all-ones a");
      // R7
      dec_carry_chk: assert (!(sel_i == 2'b11 && !cin_i) || (cout_o == (|a_i)))
         else $error("decrement carry does not match nonzero a");
      // R8
      pass_set_chk: assert (!(sel_i == 2'b11 && cin_i) || (d_o == a_i && cout_o))
         else $error("pass with ones does not hold a and set carry");
   end

endmodule

bind arith_sel_unit arith_sel_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .sel_i  (sel_i),
   .cin_i  (cin_i),
   .d_o    (d_o),
   .cout_o (cout_o)
);

// File: tb/test_arith_sel_unit.sv
`timescale 1ns/1ps
module test_arith_sel_unit;

   localparam int unsigned W        = 8;
   localparam int unsigned N_RANDOM = 3000;
   localparam int unsigned WD_LIMIT = 100000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [1:0]   sel;
   logic         cin;
   logic [W-1:0] d_rip, d_cla;
   logic         c_rip, c_cla;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   arith_sel_unit #(.WIDTH(W), .USE_LOOKAHEAD(1'b0)) i_arith_sel_unit (
      .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin), .d_o(d_rip), .cout_o(c_rip)
   );

   arith_sel_unit #(.WIDTH(W), .USE_LOOKAHEAD(1'b1), .GROUP(4)) i_arith_sel_unit_cla (
      .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin), .d_o(d_cla), .cout_o(c_cla)
   );

   // Expected {carry, result} computed from the operation meaning
   function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic [1:0] s, input logic ci);
      logic [W-1:0] r;
      logic         c;
      case ({s, ci})
         3'b000: {c, r} = {1'b0, x} + {1'b0, y};
         3'b001: {c, r} = {1'b0, x} + {1'b0, y} + 1;
         3'b010: begin r = x - y - 1'b1; c = (x > y);  end
         3'b011: begin r = x - y;        c = (x >= y); end
         3'b100: begin r = x;            c = 1'b0;     end
         3'b101: {c, r} = {1'b0, x} + 1;
         3'b110: begin r = x - 1'b1;     c = (x != 0); end
         default: begin r = x;           c = 1'b1;     end
      endcase
      return {c, r};
   endfunction

   function automatic string req_of(input logic [1:0] s, input logic ci);
      case ({s, ci})
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b100: return "R5";
         3'b101: return "R6";
         3'b110: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic compare(input string req, input logic [W:0] act, input logic [W:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s a=%h b=%h sel=%b cin=%b actual=%h expected=%h",
                  req, a, b, sel, cin, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [1:0] s, input logic ci);
      logic [W:0] exp;
      @(negedge clk);
      a = x; b = y; sel = s; cin = ci;
      @(posedge clk);
      #1;
      exp = model(x, y, s, ci);
      compare(req_of(s, ci), {c_rip, d_rip}, exp);
      // R9: lookahead build against the same expected value
      compare("R9", {c_cla, d_cla}, exp);
   endtask

   initial begin
      a = '0; b = '0; sel = 2'b00; cin = 1'b0;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #1;
      // Reset state: all-zero inputs give zero result, no carry (R1)
      compare("R1", {c_rip, d_rip}, '0);

      // R1 carry boundary
      apply(8'hFF, 8'h01, 2'b00, 1'b0);
      apply(8'h7F, 8'h80, 2'b00, 1'b0);
      // R2 carry boundary
      apply(8'h7F, 8'h80, 2'b00, 1'b1);
      apply(8'hFF, 8'hFF, 2'b00, 1'b1);
      // R3 around a == b
      apply(8'h40, 8'h40, 2'b01, 1'b0);
      apply(8'h41, 8'h40, 2'b01, 1'b0);
      // R4 around a == b
      apply(8'h40, 8'h40, 2'b01, 1'b1);
      apply(8'h3F, 8'h40, 2'b01, 1'b1);
      apply(8'h00, 8'hFF, 2'b01, 1'b1);
      // R5 b ignored
      apply(8'hA5, 8'hFF, 2'b10, 1'b0);
      apply(8'hA5, 8'h00, 2'b10, 1'b0);
      // R6 wrap
      apply(8'hFF, 8'h3C, 2'b10, 1'b1);
      apply(8'hFE, 8'h3C, 2'b10, 1'b1);
      // R7 zero and one
      apply(8'h00, 8'h77, 2'b11, 1'b0);
      apply(8'h01, 8'h77, 2'b11, 1'b0);
      // R8 b ignored
      apply(8'h5A, 8'h00, 2'b11, 1'b1);
      apply(8'h5A, 8'hFF, 2'b11, 1'b1);

      // Random sweep over all codes, R1..R9
      for (int n = 0; n < N_RANDOM; n++) begin
         apply(W'($urandom), W'($urandom), 2'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int t = 0; t < WD_LIMIT; t++) begin
         @(posedge clk);
      end
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule